// File: doc/BRIEF.md
# Programmable Modulus Interrupt Timer

This block is a down-counting periodic timer with a small register interface. A one-cycle `tick_i` pulse moves a counter one step toward zero. When a tick brings the counter to zero, the block sets an interrupt flag. If interrupts are enabled, the flag drives `irq_o`. On the tick after zero, the counter does one of two things, chosen by a control bit. It either reloads from a modulus register, which gives a fixed period, or it wraps to all ones and keeps counting, which gives a free-running count.

Software sets up the timer through three addresses: a control/status word, the modulus latch and a read-only view of the live count. An overwrite option makes a modulus write load the counter at once. Without it, the new modulus is only picked up at the next reload. Turning the enable bit on starts the count from the modulus value.

Top module: `mod_irq_timer`

Address map: 0 is control/status, 1 is modulus, 2 is counter (read only), 3 reads as zero. Control word bits: [0] enable, [1] reload mode, [2] interrupt enable, [3] overwrite, [4] interrupt flag.

## Requirements
- R1: After reset, the control word reads 0, the modulus reads 0xFFFF, the counter reads 0xFFFF and `irq_o` is low.
- R2: While enable (bit 0) is set, each tick with a non-zero count lowers the counter by one at the next clock edge.
- R3: With reload mode (bit 1) set, a tick while the counter is 0x0000 loads the modulus value. With a modulus of 5 the counter reads 2, 1, 0, 5 on successive ticks.
- R4: With reload mode clear, a tick while the counter is 0x0000 gives 0xFFFF, whatever the modulus holds.
- R5: In both modes, the flag (bit 4) is set at the same edge where a tick makes the counter 0x0000.
- R6: `irq_o` is high exactly when the flag and interrupt enable (bit 2) are both set.
- R7: With overwrite (bit 3) set, a modulus write also loads the counter with the written value at that edge. This takes precedence over a tick in the same cycle.
- R8: With overwrite clear, a modulus write changes only the latch. The counter keeps its course, and the new value is used at the next reload.
- R9: Writing 1 to bit 4 of the control word clears the flag. If a tick reaches zero in the same cycle, the flag stays set.
- R10: While enable is clear, the counter holds and ticks are ignored. A control write that turns enable from 0 to 1 loads the counter from the modulus.
- R11: Address 2 returns the live count. Writes to address 2 change nothing, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count advance pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | CNT_W | Read data (combinational from read address) |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register result (counter, modulus, control bits, flag) changes at the clock edge that samples the tick or write, so it is due one edge after the stimulus is applied. `rd_data_o` and the default combinational `irq_o` follow that state with no further delay. The bench drives inputs at the falling edge and lets exactly one rising edge pass. It then reads all three addresses and `irq_o` before the next rising edge and compares them with a model that has been stepped by the same edge.

// File: rtl/mit_pkg.sv
package mit_pkg;
   localparam int ADDR_W = 2;
   localparam int CTRL_W = 5;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_MOD  = 2'd1;
   localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

   localparam int B_EN     = 0;
   localparam int B_RELOAD = 1;
   localparam int B_IE     = 2;
   localparam int B_OVW    = 3;
   localparam int B_FLAG   = 4;

   typedef struct packed {
      logic flag;
      logic ovw;
      logic ie;
      logic reload;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/mit_regs.sv
module mit_regs
   import mit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [ADDR_W-1:0]    wr_addr_i,
   input  logic [CNT_W-1:0]     wr_data_i,
   input  logic                 set_flag_i,
   output ctrl_t                ctrl_o,
   output logic [CNT_W-1:0]     mod_o,
   output logic                 ovw_load_o,
   output logic                 en_load_o
);
   localparam logic [CNT_W-1:0] MOD_RST = '1;

   ctrl_t            ctrl_q, ctrl_d;
   logic [CNT_W-1:0] mod_q;
   logic             ctl_wr, mod_wr;

   assign ctl_wr = wr_en_i && (wr_addr_i == A_CTRL);
   assign mod_wr = wr_en_i && (wr_addr_i == A_MOD);

   always_comb begin
      ctrl_d = ctrl_q;
      if (ctl_wr) begin
         ctrl_d.en     = wr_data_i[B_EN];
         ctrl_d.reload = wr_data_i[B_RELOAD];
         ctrl_d.ie     = wr_data_i[B_IE];
         ctrl_d.ovw    = wr_data_i[B_OVW];
         if (wr_data_i[B_FLAG]) ctrl_d.flag = 1'b0;
      end
      if (set_flag_i) ctrl_d.flag = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mod_q  <= MOD_RST;
      end else begin
         ctrl_q <= ctrl_d;
         if (mod_wr) mod_q <= wr_data_i;
      end
   end

   assign ctrl_o     = ctrl_q;
   assign mod_o      = mod_q;
   assign ovw_load_o = mod_wr && ctrl_q.ovw;
   assign en_load_o  = ctl_wr && wr_data_i[B_EN] && !ctrl_q.en;
endmodule

// File: rtl/mit_count.sv
module mit_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             reload_i,
   input  logic             ovw_load_i,
   input  logic [CNT_W-1:0] ovw_val_i,
   input  logic             en_load_i,
   input  logic [CNT_W-1:0] mod_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_evt_o
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, step_val;
   logic             step_go, at_zero;

   assign at_zero  = (cnt_q == '0);
   assign step_go  = en_i && tick_i && !ovw_load_i && !en_load_i;
   assign step_val = at_zero ? (reload_i ? mod_i : ALL_ONES) : (cnt_q - ONE);

   always_comb begin
      if (ovw_load_i)     cnt_d = ovw_val_i;
      else if (en_load_i) cnt_d = mod_i;
      else if (step_go)   cnt_d = step_val;
      else                cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= ALL_ONES;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o      = cnt_q;
   assign zero_evt_o = step_go && (step_val == '0);
endmodule

// File: rtl/mit_rdmux.sv
module mit_rdmux
   import mit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  ctrl_t             ctrl_i,
   input  logic [CNT_W-1:0]  mod_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic [CNT_W-1:0]  rd_data_o
);
   logic [CNT_W-1:0] ctrl_ext;

   generate
      if (CNT_W > CTRL_W) begin : g_pad
         assign ctrl_ext = {{(CNT_W-CTRL_W){1'b0}}, ctrl_i};
      end else begin : g_nopad
         assign ctrl_ext = ctrl_i;
      end
   endgenerate

   always_comb begin
      case (rd_addr_i)
         A_CTRL:  rd_data_o = ctrl_ext;
         A_MOD:   rd_data_o = mod_i;
         A_CNT:   rd_data_o = cnt_i;
         default: rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/mod_irq_timer.sv
module mod_irq_timer
   import mit_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 wr_en_i,
   input  logic [ADDR_W-1:0]    wr_addr_i,
   input  logic [CNT_W-1:0]     wr_data_i,
   input  logic [ADDR_W-1:0]    rd_addr_i,
   output logic [CNT_W-1:0]     rd_data_o,
   output logic                 irq_o
);
   generate
      if (CNT_W < CTRL_W || CNT_W > 32) begin : g_bad_width
         $error("mod_irq_timer: CNT_W must lie in %0d..32", CTRL_W);
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] mod_q, cnt_q;
   logic             ovw_load, en_load, zero_evt;

   mit_regs #(.CNT_W(CNT_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .set_flag_i (zero_evt),
      .ctrl_o     (ctrl_q),
      .mod_o      (mod_q),
      .ovw_load_o (ovw_load),
      .en_load_o  (en_load)
   );

   mit_count #(.CNT_W(CNT_W)) count_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .en_i       (ctrl_q.en),
      .reload_i   (ctrl_q.reload),
      .ovw_load_i (ovw_load),
      .ovw_val_i  (wr_data_i),
      .en_load_i  (en_load),
      .mod_i      (mod_q),
      .cnt_o      (cnt_q),
      .zero_evt_o (zero_evt)
   );

   mit_rdmux #(.CNT_W(CNT_W)) rdmux_i (
      .rd_addr_i (rd_addr_i),
      .ctrl_i    (ctrl_q),
      .mod_i     (mod_q),
      .cnt_i     (cnt_q),
      .rd_data_o (rd_data_o)
   );

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ctrl_q.flag && ctrl_q.ie;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = ctrl_q.flag && ctrl_q.ie;
      end
   endgenerate
endmodule

// File: rtl/mit_checker.sv
module mit_checker
   import mit_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_i,
   input logic                wr_en_i,
   input logic [ADDR_W-1:0]   wr_addr_i,
   input logic [CNT_W-1:0]    wr_data_i,
   input ctrl_t               ctrl,
   input logic [CNT_W-1:0]    mod,
   input logic [CNT_W-1:0]    cnt,
   input logic                irq
);
   logic quiet, mod_wr, ctl_wr;
   assign mod_wr = wr_en_i && (wr_addr_i == A_MOD);
   assign ctl_wr = wr_en_i && (wr_addr_i == A_CTRL);
   assign quiet  = !mod_wr && !ctl_wr;

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.en && tick_i && quiet && cnt != '0 |=> cnt == $past(cnt) - CNT_W'(1));

   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.en && ctrl.reload && tick_i && quiet && cnt == '0 |=> cnt == $past(mod));

   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.en && !ctrl.reload && tick_i && quiet && cnt == '0 |=> &cnt);

   a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.en && tick_i && quiet && cnt == CNT_W'(1) |=> ctrl.flag);

   a_r7_ovw_load: assert property (@(posedge clk) disable iff (!rst_n)
      mod_wr && ctrl.ovw |=> cnt == $past(wr_data_i));

   a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && wr_data_i[B_FLAG] && !(ctrl.en && tick_i && cnt == CNT_W'(1)) |=> !ctrl.flag);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.en && quiet |=> $stable(cnt));

   generate
      if (!IRQ_REG) begin : g_irq_chk
         a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (ctrl.flag && ctrl.ie));
      end
   endgenerate
endmodule

bind mod_irq_timer mit_checker #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .wr_data_i (wr_data_i),
   .ctrl      (ctrl_q),
   .mod       (mod_q),
   .cnt       (cnt_q),
   .irq       (irq_o)
);

// File: tb/mod_irq_timer_tb_top.sv
module mod_irq_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  wa = 2'd0;
   logic [15:0] wd = 16'd0;
   logic [1:0]  ra = 2'd2;
   logic [15:0] rd;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   // bench model state
   logic        m_en = 0, m_rel = 0, m_ie = 0, m_ovw = 0, m_flag = 0;
   logic [15:0] m_mod = 16'hFFFF, m_cnt = 16'hFFFF;

   always #10 clk = ~clk;

   mod_irq_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(we), .wr_addr_i(wa),
      .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [15:0] ctrl_word();
      return {11'd0, m_flag, m_ovw, m_ie, m_rel, m_en};
   endfunction

   function automatic logic [15:0] next_cnt(input logic t, input logic w, input logic [1:0] a,
                                            input logic [15:0] d);
      logic [15:0] sv;
      sv = (m_cnt == 0) ? (m_rel ? m_mod : 16'hFFFF) : m_cnt - 16'd1;
      if (w && a == 2'd1 && m_ovw)            return d;        // R7
      if (w && a == 2'd0 && d[0] && !m_en)    return m_mod;    // R10
      if (m_en && t)                          return sv;       // R2 R3 R4
      return m_cnt;
   endfunction

   function automatic logic zero_event(input logic t, input logic w, input logic [1:0] a,
                                       input logic [15:0] d);
      logic [15:0] sv;
      sv = (m_cnt == 0) ? (m_rel ? m_mod : 16'hFFFF) : m_cnt - 16'd1;
      if (w && a == 2'd1 && m_ovw) return 1'b0;
      if (w && a == 2'd0 && d[0] && !m_en) return 1'b0;
      return m_en && t && sv == 16'd0;
   endfunction

   task automatic model_edge(input logic t, input logic w, input logic [1:0] a, input logic [15:0] d);
      logic [15:0] nc;
      logic        ev;
      nc = next_cnt(t, w, a, d);
      ev = zero_event(t, w, a, d);
      if (w && a == 2'd0) begin
         m_en = d[0]; m_rel = d[1]; m_ie = d[2]; m_ovw = d[3];
         if (d[4]) m_flag = 1'b0;                          // R9
      end
      if (ev) m_flag = 1'b1;                               // R5, set wins
      if (w && a == 2'd1) m_mod = d;                       // R8
      m_cnt = nc;
   endtask

   // called at a falling edge; applies inputs across one rising edge
   task automatic step(input logic t, input logic w, input logic [1:0] a, input logic [15:0] d);
      tick = t; we = w; wa = a; wd = d;
      @(posedge clk);
      model_edge(t, w, a, d);
      @(negedge clk);
      tick = 0; we = 0;
   endtask

   task automatic compare_all();
      ra = 2'd2; #1 chk("R11 counter read", rd, m_cnt);
      ra = 2'd1; #1 chk("R8 modulus read", rd, m_mod);
      ra = 2'd0; #1 chk("R5 control read", rd, ctrl_word());
      chk("R6 irq", irq, m_flag && m_ie);
      ra = 2'd2;
   endtask

   task automatic read_cnt(input string req, input logic [15:0] exp);
      ra = 2'd2; #1 chk(req, rd, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (2) @(negedge clk);
      // R1 reset state
      ra = 2'd0; #1 chk("R1 ctrl reset", rd, 16'h0000);
      ra = 2'd1; #1 chk("R1 modulus reset", rd, 16'hFFFF);
      ra = 2'd2; #1 chk("R1 counter reset", rd, 16'hFFFF);
      chk("R1 irq reset", irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 ticks ignored while disabled
      repeat (3) step(1, 0, 0, 0);
      read_cnt("R10 hold while disabled", 16'hFFFF);
      // R3 reload sequence, modulus 5
      step(0, 1, 2'd1, 16'd5);
      step(0, 1, 2'd0, 16'h0007);
      read_cnt("R10 enable loads modulus", 16'd5);
      step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 0, 0, 0);
      read_cnt("R3 sequence 2", 16'd2);
      step(1, 0, 0, 0); read_cnt("R3 sequence 1", 16'd1);
      step(1, 0, 0, 0); read_cnt("R3 sequence 0", 16'd0);
      ra = 2'd0; #1 chk("R5 flag set at zero", rd[4], 1'b1);
      chk("R6 irq high", irq, 1'b1);
      step(1, 0, 0, 0); read_cnt("R3 reload to 5", 16'd5);
      compare_all();
      // R9 clear
      step(0, 1, 2'd0, 16'h0017);
      chk("R9 irq after clear", irq, 1'b0);
      compare_all();
      // R9 set wins
      repeat (4) step(1, 0, 0, 0);
      read_cnt("R2 counted to 1", 16'd1);
      step(1, 1, 2'd0, 16'h0017);
      ra = 2'd0; #1 chk("R9 set wins over clear", rd[4], 1'b1);
      // R4 free-running wrap
      step(0, 1, 2'd0, 16'h0015);
      step(1, 0, 0, 0); read_cnt("R4 wrap to all ones", 16'hFFFF);
      step(1, 0, 0, 0); read_cnt("R2 decrement after wrap", 16'hFFFE);
      // R8 latch-only modulus write
      step(0, 1, 2'd1, 16'd3);
      read_cnt("R8 counter unchanged", 16'hFFFE);
      // R7 overwrite, tick in the same cycle loses
      step(0, 1, 2'd0, 16'h000B);
      step(1, 1, 2'd1, 16'h0010);
      read_cnt("R7 overwrite load", 16'h0010);
      // R11 counter address write ignored, address 3 zero
      step(0, 1, 2'd2, 16'h1234);
      read_cnt("R11 counter write ignored", 16'h0010);
      ra = 2'd3; #1 chk("R11 unused address", rd, 16'h0000);
      // R8 new modulus used at next reload
      step(0, 1, 2'd0, 16'h0003);
      step(0, 1, 2'd1, 16'd2);
      repeat (17) step(1, 0, 0, 0);
      read_cnt("R8 reload uses new modulus", 16'd2);
      // R10 disable holds
      step(0, 1, 2'd0, 16'h0002);
      repeat (3) step(1, 0, 0, 0);
      read_cnt("R10 hold after disable", 16'd2);
      compare_all();
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic        t, w;
         logic [1:0]  a;
         logic [15:0] d;
         t = ($urandom % 10) < 7;
         w = ($urandom % 10) < 2;
         a = 2'($urandom % 4);
         d = 16'($urandom);
         if (a == 2'd1) d = d & 16'h001F;
         if (a == 2'd0) d[0] = ($urandom % 10) < 8;
         step(t, w, a, d);
         compare_all();
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule